// File: doc/BRIEF.md
# Prescaled Timer with Overflow Interrupt

This block is a free-running up-counter that software can configure as 8 or 16 bits wide. Its count source is either a one-cycle internal tick strobe or edges of an external input. The external input is first brought into the clock domain by a synchronizer, and a control bit picks whether rising or falling edges count. An optional power-of-two prescaler sits between the source and the counter. Software cannot see the prescaler. It is reset whenever the counter is written, and it can be bypassed or given a new ratio while the timer keeps running.

When the counter wraps past its all-ones value at the selected width, a sticky overflow flag is set. Software must clear that flag. A separate enable bit gates the flag onto a registered interrupt output. Software programs an 8-bit control word, loads or reads the counter, and manages the flag and the enable.

Top module: `prescaled_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cnt_q`, `ovf_flag` and `irq` are all zero, and the control word, prescaler and interrupt enable are cleared.
- R2: With control bit 3 (bypass) at 0 and bit 7 (run) at 1, the counter advances once per 2^(n+1) source ticks, where n is control bits 2:0 (code 0 gives 1:2, code 7 gives 1:256).
- R3: With control bit 3 at 1, every source tick advances the counter by one, and the prescaler count stays at zero.
- R4: A counter write (`cnt_we`) loads `cnt_wdata` into the counter on the next cycle and zeroes the prescaler count, so a full new prescale period must pass before the next advance. The control word is not changed.
- R5: The prescale ratio and the bypass bit can be rewritten while the timer runs. The prescaler count carries over a ratio change.
- R6: With control bit 6 at 1 (8-bit width), only bits 7:0 count. A wrap from FFh to 00h sets `ovf_flag`, and bits 15:8 keep their value.
- R7: With control bit 6 at 0 (16-bit width), a wrap from FFFFh to 0000h sets `ovf_flag`. A carry such as 00FFh to 0100h does not set it.
- R8: `irq` equals `ovf_flag` AND the interrupt enable written through `ie_we`/`ie_wdata`. A cleared enable masks `irq`, but the flag is still set on overflow.
- R9: `ovf_flag` stays set until `flag_clr` is pulsed. If a clear and an overflow fall in the same cycle, the flag ends up set.
- R10: With control bit 7 at 0, the counter and the prescaler hold their values. A counter write still loads the counter.
- R11: With control bit 5 at 1, the source is `ext_in` after a two-stage synchronizer. Bit 4 selects the edge (0 rising, 1 falling). An input edge placed before clock edge k advances the counter at edge k+2 when bypassed.
- R12: A counter write in the same cycle as a source tick takes priority. The written value appears unchanged, and that tick is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 8 | Control word: [7] run, [6] 8-bit width, [5] external source, [4] falling edge, [3] prescaler bypass, [2:0] ratio code |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Value loaded into the counter |
| cnt_q | output | CNT_W | Counter read value |
| tick_en | input | 1 | Internal source tick, one cycle per tick |
| ext_in | input | 1 | Asynchronous external count input |
| ie_we | input | 1 | Interrupt enable write strobe |
| ie_wdata | input | 1 | New interrupt enable value |
| flag_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request (flag gated by enable) |

## Verification
The bench compares the counter, flag and interrupt against a behavioural model on every clock, and adds directed checks with hand-computed values.

The directed checks target these corner cases:
- Each of the eight ratio codes is checked one tick before and one tick after the third advance. An off-by-one in the mask decoding or in the shift width would show up as an early or late count.
- A counter write lands mid-period. A design that forgot to clear the prescaler would advance too soon after the write.
- The run bit is turned off and on around a partly filled prescaler. A design that reset the prescaler would miss that advance.
- Carries 00FFh to 0100h and the 8-bit wrap of 12FEh are checked. A design that used the wrong width for the wrap test would raise a false flag or corrupt the high byte.
- A clear and an overflow arrive in the same cycle. A design that gave priority to the clear would lose the interrupt.
- External pulses are counted on both edges with the two-cycle synchronizer latency checked exactly.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int RATIO_W = 3;
  localparam int CTRL_W  = 8;

  // Control word layout, MSB first
  typedef struct packed {
    logic               run;
    logic               narrow;
    logic               ext_sel;
    logic               fall_sel;
    logic               bypass;
    logic [RATIO_W-1:0] ratio;
  } ctrl_t;
endpackage

// File: rtl/ptimer_src.sv
module ptimer_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  input  logic tick_in,
  input  logic ext_sel,
  input  logic fall_sel,
  input  logic run,
  output logic tick_out
);
  // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] chain;
  logic rise, fall, ext_tick;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_STAGES-1:0], ext_in};
  end

  assign rise     = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
  assign fall     = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];
  assign ext_tick = fall_sel ? fall : rise;
  assign tick_out = run & (ext_sel ? ext_tick : tick_in);
endmodule

// File: rtl/ptimer_prescale.sv
module ptimer_prescale #(
  parameter int PRE_W   = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               src_tick,
  input  logic               bypass,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               clear,
  output logic               step,
  output logic [PRE_W-1:0]   pre_count
);
  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  logic [RATIO_W:0]   shamt;
  logic [PRE_W-1:0]   mask;
  logic               period_end;

  // divide by 2^(ratio+1): advance when the low ratio+1 bits are all ones
  assign shamt      = {1'b0, ratio} + {{RATIO_W{1'b0}}, 1'b1};
  assign mask       = (ONE << shamt) - ONE;
  assign period_end = (pre_count & mask) == mask;
  assign step       = src_tick & (bypass | period_end);

  always_ff @(posedge clk) begin
    if (rst || bypass || clear) pre_count <= '0;
    else if (src_tick)          pre_count <= pre_count + ONE;
  end
endmodule

// File: rtl/ptimer_count.sv
module ptimer_count #(
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  input  logic             narrow,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [NARROW_W-1:0] ONE_N = NARROW_W'(1);
  localparam logic [CNT_W-1:0]    ONE_W = CNT_W'(1);

  logic at_top;

  assign at_top = narrow ? (&cnt[NARROW_W-1:0]) : (&cnt);
  assign wrap   = step & ~load & at_top;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) begin
      if (narrow) cnt <= {cnt[CNT_W-1:NARROW_W], cnt[NARROW_W-1:0] + ONE_N};
      else        cnt <= cnt + ONE_W;
    end
  end
endmodule

// File: rtl/ptimer_irq.sv
module ptimer_irq (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic ie_we,
  input  logic ie_d,
  output logic flag,
  output logic ie,
  output logic irq
);
  logic flag_n, ie_n;

  assign flag_n = set | (flag & ~clr);
  assign ie_n   = ie_we ? ie_d : ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      ie   <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_n;
      ie   <= ie_n;
      irq  <= flag_n & ie_n;
    end
  end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int CNT_W       = 16,
  parameter int NARROW_W    = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ctrl_we,
  input  logic [ptimer_pkg::CTRL_W-1:0]  ctrl_wdata,
  input  logic                           cnt_we,
  input  logic [CNT_W-1:0]               cnt_wdata,
  output logic [CNT_W-1:0]               cnt_q,
  input  logic                           tick_en,
  input  logic                           ext_in,
  input  logic                           ie_we,
  input  logic                           ie_wdata,
  input  logic                           flag_clr,
  output logic                           ovf_flag,
  output logic                           irq
);
  import ptimer_pkg::*;

  ctrl_t            ctrl_r;
  logic             src_tick;
  logic             step;
  logic             wrap;
  logic             ie_r;
  logic [PRE_W-1:0] pre_count;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_r <= '0;
    else if (ctrl_we) ctrl_r <= ctrl_t'(ctrl_wdata);
  end

  ptimer_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst(rst), .ext_in(ext_in), .tick_in(tick_en),
    .ext_sel(ctrl_r.ext_sel), .fall_sel(ctrl_r.fall_sel), .run(ctrl_r.run),
    .tick_out(src_tick)
  );

  ptimer_prescale #(.PRE_W(PRE_W), .RATIO_W(RATIO_W)) u_pre (
    .clk(clk), .rst(rst), .src_tick(src_tick), .bypass(ctrl_r.bypass),
    .ratio(ctrl_r.ratio), .clear(cnt_we), .step(step), .pre_count(pre_count)
  );

  ptimer_count #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_we), .load_val(cnt_wdata), .step(step),
    .narrow(ctrl_r.narrow), .cnt(cnt_q), .wrap(wrap)
  );

  ptimer_irq u_irq (
    .clk(clk), .rst(rst), .set(wrap), .clr(flag_clr), .ie_we(ie_we),
    .ie_d(ie_wdata), .flag(ovf_flag), .ie(ie_r), .irq(irq)
  );
endmodule

// File: rtl/ptimer_checker.sv
module ptimer_checker #(
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8,
  parameter int PRE_W    = 8
) (
  input logic                 clk,
  input logic                 rst,
  input ptimer_pkg::ctrl_t    ctrl,
  input logic                 cnt_we,
  input logic [CNT_W-1:0]     cnt_wdata,
  input logic [CNT_W-1:0]     cnt_q,
  input logic [PRE_W-1:0]     pre_count,
  input logic                 step,
  input logic                 flag_clr,
  input logic                 ovf_flag,
  input logic                 ie,
  input logic                 irq
);
  assert_bypass_zero_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl.bypass |=> pre_count == '0);

  assert_load_clears_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt_q == $past(cnt_wdata)) && (pre_count == '0));

  assert_narrow_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !cnt_we && ctrl.narrow && (&cnt_q[NARROW_W-1:0]))
      |=> ovf_flag && (cnt_q[CNT_W-1:NARROW_W] == $past(cnt_q[CNT_W-1:NARROW_W])));

  assert_wide_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !cnt_we && !ctrl.narrow && (&cnt_q)) |=> ovf_flag && (cnt_q == '0));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    irq == (ovf_flag && ie));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  assert_hold_count_R10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !cnt_we) |=> $stable(cnt_q));

  assert_hold_pre_R10: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !cnt_we && !ctrl.bypass) |=> $stable(pre_count));
endmodule

bind prescaled_timer ptimer_checker #(.CNT_W(CNT_W), .NARROW_W(NARROW_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl_r), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
  .cnt_q(cnt_q), .pre_count(pre_count), .step(step), .flag_clr(flag_clr),
  .ovf_flag(ovf_flag), .ie(ie_r), .irq(irq)
);

// File: tb/prescaled_timer_bench.sv
module prescaled_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctrl_we = 1'b0;
  logic [7:0]  ctrl_wdata = '0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic [15:0] cnt_q;
  logic        tick_en = 1'b0;
  logic        ext_in = 1'b0;
  logic        ie_we = 1'b0;
  logic        ie_wdata = 1'b0;
  logic        flag_clr = 1'b0;
  logic        ovf_flag;
  logic        irq;

  int    total = 0;
  int    fails = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  prescaled_timer u_prescaled_timer (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .tick_en(tick_en),
    .ext_in(ext_in), .ie_we(ie_we), .ie_wdata(ie_wdata), .flag_clr(flag_clr),
    .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int       m_cnt, m_p, m_ratio, m_mask;
  bit       m_flag, m_ie, m_inc, m_ovf, m_tick, m_edge;
  bit [7:0] m_ctrl;
  bit       h1, h2, h3;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_p = 0; m_flag = 0; m_ie = 0; m_ctrl = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      m_edge  = m_ctrl[4] ? (!h2 && h3) : (h2 && !h3);
      m_tick  = m_ctrl[7] && (m_ctrl[5] ? m_edge : tick_en);
      m_ratio = int'(m_ctrl[2:0]);
      m_mask  = (1 << (m_ratio + 1)) - 1;
      m_inc = 0; m_ovf = 0;
      if (cnt_we) begin
        m_cnt = int'(cnt_wdata); m_p = 0;
      end else if (m_tick) begin
        if (m_ctrl[3]) m_inc = 1;
        else begin
          m_inc = ((m_p & m_mask) == m_mask);
          m_p = (m_p + 1) % 256;
        end
      end
      if (m_ctrl[3]) m_p = 0;
      if (m_inc) begin
        if (m_ctrl[6]) begin
          m_ovf = ((m_cnt & 255) == 255);
          m_cnt = (m_cnt & 32'hFF00) | ((m_cnt + 1) & 255);
        end else begin
          m_ovf = (m_cnt == 65535);
          m_cnt = (m_cnt + 1) & 65535;
        end
      end
      if (m_ovf) m_flag = 1; else if (flag_clr) m_flag = 0;
      if (ie_we) m_ie = ie_wdata;
      if (ctrl_we) m_ctrl = ctrl_wdata;
      h3 = h2; h2 = h1; h1 = ext_in;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, 32'(cnt_q), 32'(m_cnt));
      check(cur_req, 32'(ovf_flag), 32'(m_flag));
      check(cur_req, 32'(irq), 32'(m_flag & m_ie));
    end
  end

  task automatic cyc();
    @(negedge clk);
    ctrl_we = 0; cnt_we = 0; ie_we = 0; flag_clr = 0;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1; ctrl_wdata = v;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_we = 1; cnt_wdata = v;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) cyc();
    check("R1", 32'(cnt_q), 0);
    check("R1", 32'(ovf_flag), 0);
    check("R1", 32'(irq), 0);
    rst = 0;
    cyc();
    check("R1", 32'(cnt_q), 0);

    // R2: every ratio code, third advance
    cur_req = "R2";
    for (int n = 0; n < 8; n++) begin
      wr_ctrl(8'h80 | 8'(n)); wr_cnt(16'h0000); cyc();
      tick_en = 1;
      repeat (3 * (1 << (n + 1)) - 1) cyc();
      check("R2", 32'(cnt_q), 2);
      cyc();
      check("R2", 32'(cnt_q), 3);
      tick_en = 0;
    end

    // R3: bypass
    cur_req = "R3";
    wr_ctrl(8'h88); wr_cnt(16'h0000); cyc();
    tick_en = 1; repeat (10) cyc(); tick_en = 0;
    check("R3", 32'(cnt_q), 10);

    // R4: counter write clears prescaler mid-period
    cur_req = "R4";
    wr_ctrl(8'h83); wr_cnt(16'h0000); cyc();
    tick_en = 1; repeat (10) cyc();
    tick_en = 0; wr_cnt(16'h0100); cyc();
    tick_en = 1; repeat (15) cyc();
    check("R4", 32'(cnt_q), 32'h100);
    cyc();
    check("R4", 32'(cnt_q), 32'h101);
    tick_en = 0;

    // R12: write beats tick
    cur_req = "R12";
    wr_ctrl(8'h88); cyc();
    tick_en = 1; wr_cnt(16'h0050); cyc();
    check("R12", 32'(cnt_q), 32'h50);
    cyc(); tick_en = 0;
    check("R12", 32'(cnt_q), 32'h51);

    // R7: 16-bit wrap and carry
    cur_req = "R7";
    wr_cnt(16'h00FE); cyc();
    tick_en = 1; repeat (2) cyc(); tick_en = 0;
    check("R7", 32'(cnt_q), 32'h0100);
    check("R7", 32'(ovf_flag), 0);
    wr_cnt(16'hFFFE); cyc();
    tick_en = 1; cyc();
    check("R7", 32'(ovf_flag), 0);
    cyc(); tick_en = 0;
    check("R7", 32'(cnt_q), 0);
    check("R7", 32'(ovf_flag), 1);

    // R8: masking
    cur_req = "R8";
    check("R8", 32'(irq), 0);
    ie_we = 1; ie_wdata = 1; cyc();
    check("R8", 32'(irq), 1);
    ie_we = 1; ie_wdata = 0; cyc();
    check("R8", 32'(irq), 0);
    check("R8", 32'(ovf_flag), 1);
    ie_we = 1; ie_wdata = 1; cyc();

    // R9: sticky, clear, simultaneous clear and overflow
    cur_req = "R9";
    repeat (3) cyc();
    check("R9", 32'(ovf_flag), 1);
    flag_clr = 1; cyc();
    check("R9", 32'(ovf_flag), 0);
    check("R9", 32'(irq), 0);
    wr_cnt(16'hFFFF); cyc();
    tick_en = 1; flag_clr = 1; cyc(); tick_en = 0;
    check("R9", 32'(ovf_flag), 1);
    check("R9", 32'(irq), 1);

    // R6: 8-bit wrap keeps high byte
    cur_req = "R6";
    wr_ctrl(8'hC8); wr_cnt(16'h12FE); flag_clr = 1; cyc();
    check("R6", 32'(ovf_flag), 0);
    tick_en = 1; repeat (2) cyc(); tick_en = 0;
    check("R6", 32'(cnt_q), 32'h1200);
    check("R6", 32'(ovf_flag), 1);
    flag_clr = 1; cyc();

    // R10: disabled holds counter and prescaler
    cur_req = "R10";
    wr_ctrl(8'h08); wr_cnt(16'h0033); cyc();
    tick_en = 1; repeat (5) cyc(); tick_en = 0;
    check("R10", 32'(cnt_q), 32'h33);
    wr_cnt(16'h0077); cyc();
    check("R10", 32'(cnt_q), 32'h77);
    wr_ctrl(8'h82); wr_cnt(16'h0000); cyc();
    tick_en = 1; repeat (3) cyc(); tick_en = 0;
    wr_ctrl(8'h02); cyc();
    tick_en = 1; repeat (10) cyc(); tick_en = 0;
    wr_ctrl(8'h82); cyc();
    tick_en = 1; repeat (4) cyc();
    check("R10", 32'(cnt_q), 0);
    cyc(); tick_en = 0;
    check("R10", 32'(cnt_q), 1);

    // R11: external source, rising then falling
    cur_req = "R11";
    wr_ctrl(8'hA8); wr_cnt(16'h0000); cyc();
    ext_in = 1; cyc(); cyc();
    check("R11", 32'(cnt_q), 0);
    cyc();
    check("R11", 32'(cnt_q), 1);
    ext_in = 0; repeat (3) cyc();
    for (int k = 0; k < 3; k++) begin
      ext_in = 1; repeat (3) cyc();
      ext_in = 0; repeat (3) cyc();
    end
    check("R11", 32'(cnt_q), 4);
    wr_ctrl(8'hB8); cyc();
    for (int k = 0; k < 3; k++) begin
      ext_in = 1; repeat (3) cyc();
      ext_in = 0; repeat (3) cyc();
    end
    cyc();
    check("R11", 32'(cnt_q), 7);

    // R5: ratio and bypass rewritten while running
    cur_req = "R5";
    wr_ctrl(8'h81); wr_cnt(16'hFF00); cyc();
    for (int i = 0; i < 1500; i++) begin
      tick_en = (i % 3) != 0;
      if (i % 37 == 5) wr_ctrl(8'h80 | 8'(i % 8));
      if (i % 211 == 100) wr_ctrl(8'h88);
      if (i % 97 == 50) flag_clr = 1;
      cyc();
    end
    tick_en = 0;
    cyc();

    summary();
    $finish;
  end
endmodule